// File: doc/BRIEF.md
# Codec Power-Down Sequencing Controller

This block is the power-management section of an audio codec that hangs off a serial controller link. Software reaches it through a small register port. One register index holds an 8-bit power-down control byte. The same index also returns one ready flag per section. From the control byte the block drives enable lines for the converters, the analog mixer, the reference voltage, the link and the internal clock. Each ready flag is raised only after its section has been enabled long enough to settle.

There are three ways back to a known state, and they behave differently. A cold reset returns the control byte and all settle state to defaults. An active-low reset pin holds every control bit set for as long as it is low. A pulse on the sync line while the part sleeps is a warm reset: it wakes only the link and keeps everything else.

Top module: `codec_pwr_seq`

## Requirements
- R1: The control/status register sits at index 0x26. A read there returns the control byte in bits [15:8], zeros in [7:4], and the ready flags as ADC=bit0, DAC=bit1, ANL=bit2, READY=bit3. A read at any other index returns 0.
- R2: A write at index 0x26 while the link is up loads write-data bits [15:8] into the control byte on the next clock edge. Write-data bits [7:0] and writes to any other index have no effect.
- R3: Enables are active high and follow the control byte: adc_en = !bit0, dac_en = !bit1, mix_en = !(bit2 | bit3), vref_en = !bit3, link_en = !bit4, iclk_en = !bit5.
- R4: Control bits 6 and 7 are stored and read back, but they never change any enable output.
- R5: While bit4 is set (sleep), register writes are ignored and the control byte keeps its value.
- R6: A sync pulse sampled while bit4 is set clears bit4 on that edge and leaves the other seven bits unchanged. This holds even when a write arrives in the same cycle. A sync pulse while awake has no effect.
- R7: An active-high cold reset sets the control byte to 0x00 and all ready flags to 0, immediately and for as long as it is held.
- R8: On each edge where the reset pin is sampled low, the control byte becomes 0xFF, which drives every enable low. After the pin returns high the byte stays 0xFF until software writes it.
- R9: The ready flag of a section (ADC on adc_en, DAC on dac_en, ANL on mix_en, READY on link_en) reads 1 exactly S clock edges after the edge that enabled the section. S defaults to 6, 9, 12 and 4 respectively. The flag stays 1 while the section remains enabled.
- R10: A ready flag reads 0 in the same cycle that its section's enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cold_rst | input | 1 | Asynchronous active-high cold reset |
| rst_pin_n | input | 1 | Active-low reset pin; forces all control bits set |
| sync_pulse | input | 1 | Sync-line pulse; warm reset while asleep |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (7) | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data at reg_addr |
| adc_en | output | 1 | ADC and input mux power enable |
| dac_en | output | 1 | DAC power enable |
| mix_en | output | 1 | Analog mixer power enable |
| vref_en | output | 1 | Reference voltage enable |
| link_en | output | 1 | Serial link enable |
| iclk_en | output | 1 | Internal clock enable |

## Verification
A warm-reset sync pulse and a register write can land on the same clock edge while the part is asleep. The result must be that only the link bit clears and the written data is dropped. The bench forces this in a directed case: it writes a new byte in the cycle of the sync pulse and then compares the read-back byte with the pre-sleep value minus bit4. Random traffic mixes sync pulses, reset-pin pulses and writes freely, so the two collide many more times. Each such collision is judged against a bench model that applies cold reset, then the pin, then wake, then write, in that priority.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam int CTRL_W   = 8;
   localparam int DATA_W   = 16;
   localparam int STAT_W   = 4;

   // control bit positions (software contract)
   localparam int PRB_ADC  = 0;
   localparam int PRB_DAC  = 1;
   localparam int PRB_MIX  = 2;
   localparam int PRB_VREF = 3;
   localparam int PRB_LINK = 4;
   localparam int PRB_ICLK = 5;

   // status slot order in readback
   typedef enum int {
      SEC_ADC  = 0,
      SEC_DAC  = 1,
      SEC_ANL  = 2,
      SEC_LINK = 3
   } sec_e;

   typedef struct packed {
      logic iclk;
      logic link;
      logic vref;
      logic mix;
      logic dac;
      logic adc;
   } pwr_en_t;
endpackage

// File: rtl/pd_ctrl_reg.sv
module pd_ctrl_reg
   import pd_pkg::*;
#(
   parameter int                ADDR_W  = 7,
   parameter logic [ADDR_W-1:0] INDEX   = 7'h26,
   parameter logic [CTRL_W-1:0] DEFAULT = '0
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              pin_n,
   input  logic              sync_pulse,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q
);
   logic wr_hit;
   logic asleep;

   assign wr_hit = we && (addr == INDEX);
   assign asleep = ctrl_q[PRB_LINK];

   // priority: cold reset, pin hold, wake, write
   always_ff @(posedge clk or posedge cold_rst) begin
      if (cold_rst) begin
         ctrl_q <= DEFAULT;
      end else if (!pin_n) begin
         ctrl_q <= '1;
      end else if (asleep) begin
         if (sync_pulse) ctrl_q[PRB_LINK] <= 1'b0;
      end else if (wr_hit) begin
         ctrl_q <= wdata[DATA_W-1 -: CTRL_W];
      end
   end
endmodule

// File: rtl/pd_decode.sv
module pd_decode
   import pd_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl,
   output pwr_en_t           en
);
   always_comb begin
      en.adc  = ~ctrl[PRB_ADC];
      en.dac  = ~ctrl[PRB_DAC];
      en.mix  = ~(ctrl[PRB_MIX] | ctrl[PRB_VREF]);
      en.vref = ~ctrl[PRB_VREF];
      en.link = ~ctrl[PRB_LINK];
      en.iclk = ~ctrl[PRB_ICLK];
   end
endmodule

// File: rtl/pd_settle.sv
module pd_settle #(
   parameter int SETTLE = 8
) (
   input  logic clk,
   input  logic cold_rst,
   input  logic en,
   output logic rdy
);
   localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

   if (SETTLE < 1) begin : g_bad_settle
      $error("pd_settle: SETTLE must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   always_ff @(posedge clk or posedge cold_rst) begin
      if (cold_rst) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (!en) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (!flag_q) begin
         if (cnt_q == LAST) flag_q <= 1'b1;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   // drops in the same cycle the section is powered down
   assign rdy = flag_q & en;
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
   import pd_pkg::*;
#(
   parameter int                ADDR_W       = 7,
   parameter logic [ADDR_W-1:0] INDEX        = 7'h26,
   parameter logic [7:0]        CTRL_DEFAULT = 8'h00,
   parameter int                SETTLE_ADC   = 6,
   parameter int                SETTLE_DAC   = 9,
   parameter int                SETTLE_ANL   = 12,
   parameter int                SETTLE_LINK  = 4
) (
   input  logic              clk,
   input  logic              cold_rst,
   input  logic              rst_pin_n,
   input  logic              sync_pulse,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              adc_en,
   output logic              dac_en,
   output logic              mix_en,
   output logic              vref_en,
   output logic              link_en,
   output logic              iclk_en
);
   localparam int PAD_W = DATA_W - CTRL_W - STAT_W;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("codec_pwr_seq: ADDR_W too small for index");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("codec_pwr_seq: readback layout does not fit");
   end

   function automatic int settle_of(input int s);
      case (s)
         SEC_ADC: return SETTLE_ADC;
         SEC_DAC: return SETTLE_DAC;
         SEC_ANL: return SETTLE_ANL;
         default: return SETTLE_LINK;
      endcase
   endfunction

   logic [CTRL_W-1:0] ctrl_q;
   pwr_en_t           en;
   logic [STAT_W-1:0] sec_en;
   logic [STAT_W-1:0] stat;

   pd_ctrl_reg #(
      .ADDR_W (ADDR_W),
      .INDEX  (INDEX),
      .DEFAULT(CTRL_DEFAULT)
   ) u_reg (
      .clk       (clk),
      .cold_rst  (cold_rst),
      .pin_n     (rst_pin_n),
      .sync_pulse(sync_pulse),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .ctrl_q    (ctrl_q)
   );

   pd_decode u_dec (
      .ctrl(ctrl_q),
      .en  (en)
   );

   assign sec_en[SEC_ADC]  = en.adc;
   assign sec_en[SEC_DAC]  = en.dac;
   assign sec_en[SEC_ANL]  = en.mix;
   assign sec_en[SEC_LINK] = en.link;

   for (genvar g = 0; g < STAT_W; g++) begin : g_settle
      pd_settle #(.SETTLE(settle_of(g))) u_settle (
         .clk     (clk),
         .cold_rst(cold_rst),
         .en      (sec_en[g]),
         .rdy     (stat[g])
      );
   end

   assign reg_rdata = (reg_addr == INDEX) ? {ctrl_q, {PAD_W{1'b0}}, stat} : '0;

   assign adc_en  = en.adc;
   assign dac_en  = en.dac;
   assign mix_en  = en.mix;
   assign vref_en = en.vref;
   assign link_en = en.link;
   assign iclk_en = en.iclk;
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
   parameter int                ADDR_W = 7,
   parameter logic [ADDR_W-1:0] INDEX  = 7'h26
) (
   input logic              clk,
   input logic              cold_rst,
   input logic              rst_pin_n,
   input logic              sync_pulse,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [15:0]       reg_wdata,
   input logic [7:0]        ctrl_q,
   input logic [3:0]        stat,
   input logic              adc_en,
   input logic              dac_en,
   input logic              mix_en,
   input logic              vref_en,
   input logic              link_en,
   input logic              iclk_en
);
   p_write_load_r2: assert property (@(posedge clk) disable iff (cold_rst)
      (reg_we && reg_addr == INDEX && !ctrl_q[4] && rst_pin_n)
      |=> ctrl_q == $past(reg_wdata[15:8]));

   p_vref_off_mix_off_r3: assert property (@(posedge clk) disable iff (cold_rst)
      !vref_en |-> !mix_en);

   p_upper_bits_inert_r4: assert property (@(posedge clk) disable iff (cold_rst)
      $stable(ctrl_q[5:0]) |-> $stable({adc_en, dac_en, mix_en, vref_en, link_en, iclk_en}));

   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (cold_rst)
      (ctrl_q[4] && !sync_pulse && rst_pin_n) |=> $stable(ctrl_q));

   p_warm_wake_r6: assert property (@(posedge clk) disable iff (cold_rst)
      (ctrl_q[4] && sync_pulse && rst_pin_n)
      |=> (!ctrl_q[4] && ctrl_q[7:5] == $past(ctrl_q[7:5]) && ctrl_q[3:0] == $past(ctrl_q[3:0])));

   p_pin_forces_r8: assert property (@(posedge clk) disable iff (cold_rst)
      !rst_pin_n |=> (ctrl_q == 8'hFF && !link_en && !adc_en));

   p_rdy_needs_en_r9: assert property (@(posedge clk) disable iff (cold_rst)
      (stat[0] |-> adc_en) and (stat[1] |-> dac_en) and (stat[2] |-> mix_en) and (stat[3] |-> link_en));

   p_rdy_drop_r10: assert property (@(posedge clk) disable iff (cold_rst)
      $fell(link_en) |-> !stat[3]);
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(.ADDR_W(ADDR_W), .INDEX(INDEX)) u_chk (
   .clk       (clk),
   .cold_rst  (cold_rst),
   .rst_pin_n (rst_pin_n),
   .sync_pulse(sync_pulse),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .ctrl_q    (ctrl_q),
   .stat      (stat),
   .adc_en    (adc_en),
   .dac_en    (dac_en),
   .mix_en    (mix_en),
   .vref_en   (vref_en),
   .link_en   (link_en),
   .iclk_en   (iclk_en)
);

// File: tb/codec_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb_top;
   localparam int S_ADC = 6, S_DAC = 9, S_ANL = 12, S_LNK = 4;
   localparam logic [6:0] IDX = 7'h26;
   localparam int MAX_CYC = 100000;

   logic        clk = 1'b0;
   logic        cold_rst = 1'b1, rst_pin_n = 1'b1, sync_pulse = 1'b0, reg_we = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic adc_en, dac_en, mix_en, vref_en, link_en, iclk_en;

   always #2.5 clk = ~clk;

   codec_pwr_seq #(
      .SETTLE_ADC(S_ADC), .SETTLE_DAC(S_DAC), .SETTLE_ANL(S_ANL), .SETTLE_LINK(S_LNK)
   ) dut_i (
      .clk(clk), .cold_rst(cold_rst), .rst_pin_n(rst_pin_n), .sync_pulse(sync_pulse),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .adc_en(adc_en), .dac_en(dac_en), .mix_en(mix_en), .vref_en(vref_en),
      .link_en(link_en), .iclk_en(iclk_en)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] pr_m;
   int         cnt_m [4];
   bit         flg_m [4];

   function automatic int settle(input int i);
      case (i) 0: return S_ADC; 1: return S_DAC; 2: return S_ANL; default: return S_LNK; endcase
   endfunction

   function automatic logic [3:0] sec_on(input logic [7:0] p);
      return {~p[4], ~(p[2] | p[3]), ~p[1], ~p[0]};
   endfunction

   function automatic logic [5:0] exp_en(input logic [7:0] p);
      return {~p[5], ~p[4], ~p[3], ~(p[2] | p[3]), ~p[1], ~p[0]};
   endfunction

   function automatic logic [15:0] exp_rd(input logic [6:0] a);
      logic [3:0] st;
      logic [3:0] on;
      on = sec_on(pr_m);
      for (int i = 0; i < 4; i++) st[i] = flg_m[i] & on[i];
      return (a == IDX) ? {pr_m, 4'b0000, st} : 16'h0000;
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [3:0] on;
      on = sec_on(pr_m);
      if (cold_rst) begin
         pr_m = 8'h00;
         for (int i = 0; i < 4; i++) begin cnt_m[i] = 0; flg_m[i] = 0; end
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (!on[i]) begin cnt_m[i] = 0; flg_m[i] = 0; end
            else if (!flg_m[i]) begin
               if (cnt_m[i] == settle(i) - 1) flg_m[i] = 1;
               else cnt_m[i]++;
            end
         end
         if (!rst_pin_n) pr_m = 8'hFF;
         else if (pr_m[4]) begin if (sync_pulse) pr_m[4] = 1'b0; end
         else if (reg_we && reg_addr == IDX) pr_m = reg_wdata[15:8];
      end
   endtask

   // apply inputs, take one edge, update model, compare outputs
   task automatic step(input logic we, input logic [6:0] a, input logic [15:0] wd,
                       input logic sy, input logic pin, input logic cr, input string tag);
      reg_we = we; reg_addr = a; reg_wdata = wd; sync_pulse = sy; rst_pin_n = pin; cold_rst = cr;
      @(posedge clk);
      #1;
      model_edge();
      chk(reg_rdata, exp_rd(a), tag);
      chk({10'd0, iclk_en, link_en, vref_en, mix_en, dac_en, adc_en}, {10'd0, exp_en(pr_m)}, "R3");
   endtask

   task automatic rd(input string tag);
      step(1'b0, IDX, 16'h0, 1'b0, 1'b1, 1'b0, tag);
   endtask

   task automatic wr(input logic [15:0] wd, input string tag);
      step(1'b1, IDX, wd, 1'b0, 1'b1, 1'b0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > MAX_CYC && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYC);
         finish_run();
      end
   end

   initial begin
      pr_m = 8'h00;
      for (int i = 0; i < 4; i++) begin cnt_m[i] = 0; flg_m[i] = 0; end
      void'($urandom(32'h5EED_0A26));

      // R7 reset state
      step(1'b0, IDX, 16'h0, 1'b0, 1'b1, 1'b1, "R7");
      chk(reg_rdata, 16'h0000, "R7");
      step(1'b0, IDX, 16'h0, 1'b0, 1'b1, 1'b1, "R7");

      // R9 exact settle timing of ADC flag from cold release
      for (int k = 1; k < S_ADC; k++) rd("R9");
      chk({15'd0, reg_rdata[0]}, 16'd0, "R9");
      rd("R9");
      chk({15'd0, reg_rdata[0]}, 16'd1, "R9");
      for (int k = 0; k < S_ANL; k++) rd("R9");
      chk(reg_rdata, 16'h000F, "R1");

      // R1 other index reads zero
      step(1'b0, 7'h24, 16'h0, 1'b0, 1'b1, 1'b0, "R1");
      chk(reg_rdata, 16'h0000, "R1");

      // R2 write elsewhere and low byte ignored
      step(1'b1, 7'h24, 16'hFFFF, 1'b0, 1'b1, 1'b0, "R2");
      wr(16'h00F0, "R2");
      chk(reg_rdata, 16'h000F, "R2");

      // R4 unsupported bits stored, no effect
      wr(16'hC000, "R4");
      chk(reg_rdata[15:8], 8'hC0, "R4");
      chk({10'd0, iclk_en, link_en, vref_en, mix_en, dac_en, adc_en}, 16'h003F, "R4");

      // R10 ADC flag drops with enable
      wr(16'h0100, "R10");
      chk({15'd0, reg_rdata[0]}, 16'd0, "R10");

      // R5 sleep ignores writes
      wr(16'h1300, "R5");
      wr(16'h0000, "R5");
      chk(reg_rdata[15:8], 8'h13, "R5");

      // R6 wake with colliding write: only bit4 clears
      step(1'b1, IDX, 16'h2000, 1'b1, 1'b1, 1'b0, "R6");
      chk(reg_rdata[15:8], 8'h03, "R6");
      step(1'b0, IDX, 16'h0, 1'b1, 1'b1, 1'b0, "R6");
      chk(reg_rdata[15:8], 8'h03, "R6");

      // R8 pin hold and release
      step(1'b1, IDX, 16'h0000, 1'b0, 1'b0, 1'b0, "R8");
      chk(reg_rdata[15:8], 8'hFF, "R8");
      chk({10'd0, iclk_en, link_en, vref_en, mix_en, dac_en, adc_en}, 16'h0000, "R8");
      rd("R8");
      chk(reg_rdata[15:8], 8'hFF, "R8");
      step(1'b1, IDX, 16'h0000, 1'b1, 1'b1, 1'b0, "R6");
      chk(reg_rdata[15:8], 8'hEF, "R6");
      wr(16'h0000, "R2");
      chk(reg_rdata[15:8], 8'h00, "R2");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [6:0]  a;
         logic [15:0] wd;
         logic        we, sy, pin, cr;
         int          r;
         r   = $urandom_range(0, 99);
         a   = (r < 80) ? IDX : 7'($urandom_range(0, 127));
         wd  = 16'($urandom());
         if ($urandom_range(0, 3) == 0) wd[15:8] = 8'h00;
         we  = ($urandom_range(0, 9) < 2);
         sy  = ($urandom_range(0, 19) == 0);
         pin = ($urandom_range(0, 99) != 0);
         cr  = ($urandom_range(0, 299) == 0);
         step(we, a, wd, sy, pin, cr, "R9");
      end

      finish_run();
   end
endmodule